// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the fetch address for a small microcontroller core. It holds a 13-bit program counter and an eight-entry hardware return stack. On each clock the core presents a control code, and the sequencer computes the next fetch address from it. The code can advance to the following word, load a branch target, load a subroutine target while saving the return point, or restore a saved return point. An interrupt request overrides the control code. It saves the return point and sends the fetch to the interrupt entry address.

A configuration input selects how much program memory is implemented: 4K words or 8K words. Every address the counter loads is folded into that space, so the fetch can never reach unimplemented words. The return stack cannot be addressed. Subroutine calls and interrupts share it, and it is circular. Once it holds eight entries, a further save overwrites the oldest one. A restore from an empty stack returns whatever the slot holds, and the core sees no error flag. A depth output reports how many entries are currently valid.

Top module: `fetch_seq`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0000h and `depth_o` is 0, and all stack slots are cleared to zero.
- R2: With `irq_i` low and code 3'b000 (advance), the next `pc_o` is `pc_o + 1`, folded per R3.
- R3: Every loaded address is folded to the implemented space. With `mem8k_i` = 0 (4K words), bit 12 is forced to 0. With `mem8k_i` = 1 (8K words), the address is taken modulo 8192, so an advance from 1FFFh gives 0000h.
- R4: With `irq_i` low and code 3'b001 (jump), the next `pc_o` is `target_i`, folded per R3, and the stack is untouched.
- R5: With `irq_i` low and code 3'b010 (call), the address `pc_o + 1` (folded) is saved on the stack and the next `pc_o` is `target_i`, folded per R3.
- R6: With `irq_i` low, codes 3'b011 (return), 3'b100 (return from interrupt) and 3'b101 (return with literal) have the same effect. Each removes the newest stack entry and loads it, folded per R3, into `pc_o`.
- R7: When `irq_i` is high, the control code is ignored. The address `pc_o + 1` (folded) is saved on the stack and the next `pc_o` is 0004h.
- R8: `depth_o` rises by one on each save and falls by one on each restore. It stays between 0 and 8 and saturates at both ends.
- R9: The stack is circular. A ninth save overwrites the oldest entry. A restore from an empty stack loads the slot just below the write position and leaves `depth_o` at 0.
- R10: Codes 3'b110 and 3'b111 behave as advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt taken in this cycle |
| op_i | input | 3 | Control code for this cycle |
| target_i | input | 13 | Branch or call target address |
| mem8k_i | input | 1 | 1 = 8K-word program space, 0 = 4K-word space |
| pc_o | output | 13 | Current fetch address |
| depth_o | output | 4 | Number of valid return-stack entries |

## Verification
Each result is due exactly one rising edge after the inputs that cause it. The counter and the stack are each a single register stage, and no path goes through another register. The bench changes the inputs on the falling edge and samples `pc_o` and `depth_o` one time unit after the next rising edge. Every sample is compared with a model the bench advances in the same step. The fold in R3 uses the value of `mem8k_i` present at that edge. For this reason the bench switches the size only between steps, and it includes a restore made after the switch of an address that was saved under the other size.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;
    typedef enum logic [2:0] {
        OP_STEP   = 3'd0,
        OP_JUMP   = 3'd1,
        OP_CALL   = 3'd2,
        OP_RET    = 3'd3,
        OP_RETI   = 3'd4,
        OP_RETLIT = 3'd5
    } seq_op_e;
endpackage

// File: rtl/fseq_next_addr.sv
`timescale 1ns/1ps
module fseq_next_addr #(
    parameter int ADDR_W   = 13,
    parameter int SMALL_AW = 12,
    parameter logic [ADDR_W-1:0] IRQ_VEC = 13'h0004
) (
    input  logic [ADDR_W-1:0] pc_q,
    input  logic              irq_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              mem8k_i,
    input  logic [ADDR_W-1:0] top_val,
    output logic [ADDR_W-1:0] pc_d,
    output logic              push,
    output logic              pop,
    output logic [ADDR_W-1:0] push_val
);
    import fseq_pkg::*;

    localparam logic [ADDR_W-1:0] SMALL_MASK =
        {{(ADDR_W-SMALL_AW){1'b0}}, {SMALL_AW{1'b1}}};
    localparam logic [ADDR_W-1:0] ONE = 1;

    function automatic logic [ADDR_W-1:0] fold(input logic [ADDR_W-1:0] a,
                                               input logic big);
        return big ? a : (a & SMALL_MASK);
    endfunction

    logic [ADDR_W-1:0] seq_addr;

    always_comb begin
        seq_addr = fold(pc_q + ONE, mem8k_i);
        push     = 1'b0;
        pop      = 1'b0;
        push_val = seq_addr;
        pc_d     = seq_addr;
        if (irq_i) begin
            push = 1'b1;
            pc_d = IRQ_VEC;
        end else begin
            case (op_i)
                OP_JUMP: pc_d = fold(target_i, mem8k_i);
                OP_CALL: begin
                    push = 1'b1;
                    pc_d = fold(target_i, mem8k_i);
                end
                OP_RET, OP_RETI, OP_RETLIT: begin
                    pop  = 1'b1;
                    pc_d = fold(top_val, mem8k_i);
                end
                default: pc_d = seq_addr;
            endcase
        end
    end
endmodule

// File: rtl/fseq_ret_stack.sv
`timescale 1ns/1ps
module fseq_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     push_val,
    output logic [W-1:0]     top_val,
    output logic [CNT_W-1:0] depth
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_ONE  = 1;
    localparam logic [CNT_W-1:0] CNT_ONE  = 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slots;
        logic [PTR_W-1:0]        wr_ptr;
        logic [CNT_W-1:0]        cnt;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [PTR_W-1:0] prev_ptr;

    always_comb begin
        prev_ptr = (stk_q.wr_ptr == '0) ? LAST_PTR : stk_q.wr_ptr - PTR_ONE;
        top_val  = stk_q.slots[prev_ptr];
        stk_d    = stk_q;
        if (push) begin
            stk_d.slots[stk_q.wr_ptr] = push_val;
            stk_d.wr_ptr = (stk_q.wr_ptr == LAST_PTR) ? '0 : stk_q.wr_ptr + PTR_ONE;
            if (stk_q.cnt != FULL) stk_d.cnt = stk_q.cnt + CNT_ONE;
        end else if (pop) begin
            stk_d.wr_ptr = prev_ptr;
            if (stk_q.cnt != '0) stk_d.cnt = stk_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stk_q <= '0;
        else         stk_q <= stk_d;
    end

    assign depth = stk_q.cnt;
endmodule

// File: rtl/fetch_seq.sv
`timescale 1ns/1ps
module fetch_seq #(
    parameter int ADDR_W   = 13,
    parameter int SMALL_AW = 12,
    parameter int DEPTH    = 8,
    parameter logic [ADDR_W-1:0] RESET_VEC = 13'h0000,
    parameter logic [ADDR_W-1:0] IRQ_VEC   = 13'h0004,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              irq_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              mem8k_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [CNT_W-1:0]  depth_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } core_t;

    core_t             core_d, core_q;
    logic [ADDR_W-1:0] nxt_pc, top_val, push_val;
    logic              push, pop;

    fseq_next_addr #(
        .ADDR_W(ADDR_W), .SMALL_AW(SMALL_AW), .IRQ_VEC(IRQ_VEC)
    ) i_next (
        .pc_q(core_q.pc), .irq_i(irq_i), .op_i(op_i), .target_i(target_i),
        .mem8k_i(mem8k_i), .top_val(top_val), .pc_d(nxt_pc),
        .push(push), .pop(pop), .push_val(push_val)
    );

    fseq_ret_stack #(.W(ADDR_W), .DEPTH(DEPTH)) i_stack (
        .clk_i(clk_i), .rst_ni(rst_ni), .push(push), .pop(pop),
        .push_val(push_val), .top_val(top_val), .depth(depth_o)
    );

    always_comb begin
        core_d    = core_q;
        core_d.pc = nxt_pc;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) core_q <= '{pc: RESET_VEC};
        else         core_q <= core_d;
    end

    assign pc_o = core_q.pc;
endmodule

// File: rtl/fseq_chk.sv
`timescale 1ns/1ps
module fseq_chk #(
    parameter int ADDR_W   = 13,
    parameter int SMALL_AW = 12,
    parameter int DEPTH    = 8,
    parameter logic [ADDR_W-1:0] IRQ_VEC = 13'h0004,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              irq_i,
    input logic [2:0]        op_i,
    input logic [ADDR_W-1:0] target_i,
    input logic              mem8k_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [CNT_W-1:0]  depth_o
);
    localparam logic [ADDR_W-1:0] SMALL_MASK =
        {{(ADDR_W-SMALL_AW){1'b0}}, {SMALL_AW{1'b1}}};
    localparam logic [ADDR_W-1:0] ONE   = 1;
    localparam logic [CNT_W-1:0]  C_ONE = 1;
    localparam logic [CNT_W-1:0]  FULL  = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] mask;
    logic              is_step, is_ret;
    assign mask    = mem8k_i ? '1 : SMALL_MASK;
    assign is_step = (op_i == 3'd0) || (op_i > 3'd5);
    assign is_ret  = (op_i >= 3'd3) && (op_i <= 3'd5);

    // R1
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            reset_state_chk: assert (pc_o == '0 && depth_o == '0);
        end
    end

    // R7
    irq_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |=> pc_o == IRQ_VEC);

    // R4
    jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_i && op_i == 3'd1) |=> pc_o == ($past(target_i) & $past(mask)));

    // R2
    step_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_i && is_step) |=> pc_o == (($past(pc_o) + ONE) & $past(mask)));

    // R3
    small_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem8k_i |=> pc_o[ADDR_W-1:SMALL_AW] == '0);

    // R8
    depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        depth_o <= FULL);

    // R5
    push_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_i || op_i == 3'd2) && depth_o != FULL) |=> depth_o == $past(depth_o) + C_ONE);

    // R6
    pop_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_i && is_ret && depth_o != '0) |=> depth_o == $past(depth_o) - C_ONE);

    // R9
    pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_i && is_ret && depth_o == '0) |=> depth_o == '0);
endmodule

bind fetch_seq fseq_chk #(
    .ADDR_W(ADDR_W), .SMALL_AW(SMALL_AW), .DEPTH(DEPTH), .IRQ_VEC(IRQ_VEC)
) i_fseq_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .op_i(op_i),
    .target_i(target_i), .mem8k_i(mem8k_i), .pc_o(pc_o), .depth_o(depth_o)
);

// File: tb/test_fetch_seq.sv
`timescale 1ns/1ps
module test_fetch_seq;
    logic        clk = 1'b0;
    logic        rst_ni;
    logic        irq_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [12:0] target_i = '0;
    logic        mem8k_i = 1'b0;
    logic [12:0] pc_o;
    logic [3:0]  depth_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [12:0] m_stk [8];
    int          m_wp = 0;
    int          m_d  = 0;
    logic [12:0] m_pc = '0;

    always #2 clk = ~clk;

    fetch_seq i_fetch_seq (
        .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i), .op_i(op_i),
        .target_i(target_i), .mem8k_i(mem8k_i), .pc_o(pc_o), .depth_o(depth_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] fold(input logic [12:0] a);
        return mem8k_i ? a : (a & 13'h0FFF);
    endfunction

    function automatic void m_push(input logic [12:0] v);
        m_stk[m_wp] = v;
        m_wp = (m_wp + 1) % 8;
        if (m_d < 8) m_d++;
    endfunction

    function automatic logic [12:0] m_pop();
        m_wp = (m_wp + 7) % 8;
        if (m_d > 0) m_d--;
        return m_stk[m_wp];
    endfunction

    task automatic step(input logic [2:0] op, input logic [12:0] tgt,
                        input bit irq, input string req);
        logic [12:0] inc;
        @(negedge clk);
        op_i = op; target_i = tgt; irq_i = irq;
        inc = fold(m_pc + 13'd1);
        if (irq) begin
            m_push(inc);
            m_pc = 13'h0004;
        end else begin
            case (op)
                3'd1: m_pc = fold(tgt);
                3'd2: begin m_push(inc); m_pc = fold(tgt); end
                3'd3, 3'd4, 3'd5: m_pc = fold(m_pop());
                default: m_pc = inc;
            endcase
        end
        @(posedge clk);
        #1;
        check(pc_o == m_pc, req, "pc_o", int'(pc_o), int'(m_pc));
        check(int'(depth_o) == m_d, req, "depth_o", int'(depth_o), m_d);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        rst_ni = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(pc_o == 13'h0000, "R1", "pc_o in reset", int'(pc_o), 0);
        check(depth_o == 4'd0, "R1", "depth_o in reset", int'(depth_o), 0);
        @(negedge clk);
        rst_ni = 1'b1;
        #1;
        check(pc_o == 13'h0000, "R1", "pc_o after release", int'(pc_o), 0);

        // R1: a restore from the freshly reset stack loads a cleared slot
        step(3'd3, '0, 1'b0, "R1");

        // R2 R3: full sweep of the 4K space, wrapping 0FFFh to 0000h
        for (int i = 0; i < 4100; i++) step(3'd0, '0, 1'b0, "R2_R3");

        // R4 R3: jump above the 4K space folds
        step(3'd1, 13'h1234, 1'b0, "R4");
        check(pc_o == 13'h0234, "R3", "folded jump", int'(pc_o), 'h234);

        // R10: unused codes advance
        step(3'd6, 13'h1FFF, 1'b0, "R10");
        step(3'd7, 13'h1FFF, 1'b0, "R10");

        // R3: 8K space rolls from 1FFFh to 0000h
        mem8k_i = 1'b1;
        step(3'd1, 13'h1FFC, 1'b0, "R4");
        for (int i = 0; i < 6; i++) step(3'd0, '0, 1'b0, "R3");

        // R5 R8 R6: nested calls eight deep, then restores of all three kinds
        for (int k = 1; k <= 8; k++) step(3'd2, 13'(k * 13'h0211), 1'b0, "R5");
        for (int k = 0; k < 8; k++) step(3'(3 + k % 3), '0, 1'b0, "R6");

        // R9: ninth save overwrites the oldest, then restores past empty
        for (int k = 1; k <= 9; k++) step(3'd2, 13'(k * 13'h0301 + 13'h0040), 1'b0, "R9");
        check(depth_o == 4'd8, "R8", "saturated depth", int'(depth_o), 8);
        for (int k = 0; k < 10; k++) step(3'd5, '0, 1'b0, "R9");
        check(depth_o == 4'd0, "R8", "floor depth", int'(depth_o), 0);

        // R7: interrupt overrides a call, later return from interrupt
        step(3'd1, 13'h0ABC, 1'b0, "R4");
        step(3'd2, 13'h1111, 1'b1, "R7");
        step(3'd0, '0, 1'b0, "R2");
        step(3'd0, '0, 1'b0, "R2");
        step(3'd4, '0, 1'b0, "R7");
        check(pc_o == 13'h0ABD, "R7", "return from interrupt", int'(pc_o), 'hABD);

        // R7: interrupt overrides a return
        step(3'd3, '0, 1'b1, "R7");
        step(3'd3, '0, 1'b0, "R6");

        // R3 R5: address saved in 8K space, restored after switching to 4K
        step(3'd1, 13'h1800, 1'b0, "R4");
        step(3'd2, 13'h0100, 1'b0, "R5");
        mem8k_i = 1'b0;
        step(3'd5, '0, 1'b0, "R3");
        check(pc_o == 13'h0801, "R3", "folded restore", int'(pc_o), 'h801);
        step(3'd2, 13'h1F00, 1'b0, "R5");
        check(pc_o == 13'h0F00, "R3", "folded call", int'(pc_o), 'hF00);
        step(3'd3, '0, 1'b0, "R6");

        // R7 R9: interrupts fill and wrap the stack
        for (int k = 0; k < 10; k++) step(3'd0, '0, 1'b1, "R7");
        for (int k = 0; k < 9; k++) step(3'd4, '0, 1'b0, "R9");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule